// File: doc/BRIEF.md
# Round-Robin Scheduler for Replicated Hashing Cores

This block connects one upstream FIFO, one downstream FIFO and a set of N identical hashing cores that all do the same work. Each core takes a fixed number of input words per item and then needs a fixed number of cycles before its result is ready. The scheduler pulls items from the upstream FIFO and hands each one to the next core in strict rotation. It collects the results and writes them to the downstream FIFO in the order the items were dispatched. With the starts spread out, the replicas together reach the throughput of the stages around them. For example, three cores that each need 24 cycles give one result every 8 cycles.

Dispatch needs three things to hold at once. The upstream FIFO must hold a whole item, so the core's input pipeline is fed without gaps. The next core in rotation must be idle. The downstream FIFO must have a slot that is not already reserved. The slot is reserved at dispatch, so a finished core never waits for room. If two cores finish in the same cycle, each result waits in that core's one-entry buffer, and the buffers drain in dispatch order.

Top module: `rr_core_sched`

## Requirements
- R1: After synchronous reset, up_rd_en, dn_wr_en, core_start and core_load are all low, and the first dispatch goes to core 0.
- R2: A dispatch begins only when up_count is at least PIPE_WORDS. up_rd_en is never high while the upstream FIFO is empty.
- R3: A dispatch begins only when dn_free is greater than the number of dispatched items whose results have not yet been written. With the downstream FIFO not drained, at most dn_free items are started.
- R4: Cores are started in strict rotation 0, 1, ..., N_CORES-1, 0, ... A busy core in turn stalls dispatch, and no core is skipped.
- R5: Each dispatch delivers exactly PIPE_WORDS words on core_data to a single core, on consecutive cycles, with core_load one-hot. core_start is high together with core_load for the first word only.
- R6: Two successive core starts are at least SPACING = max(ceil(EXEC_CYCLES / N_CORES), PIPE_WORDS + 1) cycles apart.
- R7: Results go to the downstream FIFO in dispatch order, even when a later-started core finishes first.
- R8: When two cores assert core_done in the same cycle, both results are kept. The earlier-dispatched result is written first and the other follows on the next cycle.
- R9: A core is not started again until its previous result has been written downstream.
- R10: dn_wr_en is never high while dn_free is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_count | input | CNT_W | Words held in the upstream FIFO (first-word-fall-through) |
| up_rd_en | output | 1 | Pops the head word of the upstream FIFO |
| up_data | input | IN_W | Head word of the upstream FIFO |
| dn_free | input | CNT_W | Free entries in the downstream FIFO |
| dn_wr_en | output | 1 | Writes dn_data into the downstream FIFO |
| dn_data | output | RES_W | Result word to the downstream FIFO |
| core_start | output | N_CORES | One-cycle start per core, with the first input word |
| core_load | output | N_CORES | Per-core input word strobe |
| core_data | output | IN_W | Input word shared by all cores |
| core_done | input | N_CORES | One-cycle result-ready pulse per core |
| core_result | input | N_CORES*RES_W | Result of core i at bits [i*RES_W +: RES_W] |

## Verification
The assertions check several behaviours on every cycle: the rotation order and spacing of starts, one-hot word delivery, the item-size condition at each upstream read burst, the bounds of the dispatch-order queue, write room downstream, and that no buffered result is overwritten or its core restarted. Only the bench scenarios can show the rest. These are the stall on a partial item, the cap on started items when downstream space runs out, the order of results when cores finish out of order or in the same cycle, and the long stall behind a slow core that is next in rotation.

// File: rtl/sched_pkg.sv
package sched_pkg;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  typedef enum logic [0:0] {
    ST_WAIT = 1'b0,
    ST_FEED = 1'b1
  } feed_st_e;

endpackage

// File: rtl/sched_order_q.sv
module sched_order_q #(
  parameter int DEPTH = 3,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wrap_inc(wp);
      if (pop)  rp <= wrap_inc(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));

  // R7
  oq_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (!full || pop));
  // R7
  oq_no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

endmodule

// File: rtl/sched_result_buf.sv
module sched_result_buf #(
  parameter int N_CORES = 3,
  parameter int RES_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_CORES-1:0]       core_done,
  input  logic [N_CORES*RES_W-1:0] core_result,
  input  logic [N_CORES-1:0]       clr,
  output logic [N_CORES-1:0]       buf_v,
  output logic [N_CORES*RES_W-1:0] buf_data
);

  for (genvar i = 0; i < N_CORES; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (core_done[i]) buf_data[i*RES_W +: RES_W] <= core_result[i*RES_W +: RES_W];
    end

    always_ff @(posedge clk) begin
      if (rst)               buf_v[i] <= 1'b0;
      else if (core_done[i]) buf_v[i] <= 1'b1;
      else if (clr[i])       buf_v[i] <= 1'b0;
    end

    // R8
    buf_no_clobber_chk: assert property (@(posedge clk) disable iff (rst)
      core_done[i] |-> !buf_v[i]);
  end

endmodule

// File: rtl/sched_dispatch.sv
module sched_dispatch import sched_pkg::*; #(
  parameter int N_CORES    = 3,
  parameter int IDX_W      = 2,
  parameter int IN_W       = 32,
  parameter int CNT_W      = 8,
  parameter int PIPE_WORDS = 4,
  parameter int SPACING    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CNT_W-1:0]   up_count,
  input  logic [IN_W-1:0]    up_data,
  output logic               up_rd_en,
  input  logic [CNT_W-1:0]   dn_free,
  input  logic               rel_vld,
  input  logic [IDX_W-1:0]   rel_idx,
  output logic [N_CORES-1:0] core_start,
  output logic [N_CORES-1:0] core_load,
  output logic [IN_W-1:0]    core_data,
  output logic               disp_vld,
  output logic [IDX_W-1:0]   disp_idx
);
  localparam int FEED_W = $clog2(PIPE_WORDS + 1);
  localparam int GAP_W  = $clog2(SPACING + 1);
  localparam int OUT_W  = $clog2(N_CORES + 1);
  localparam logic [N_CORES-1:0] ONE = N_CORES'(1);

  feed_st_e          state;
  logic [IDX_W-1:0]  ptr, sel;
  logic [FEED_W-1:0] feed_cnt;
  logic [GAP_W-1:0]  gap_cnt;
  logic [N_CORES-1:0] busy, busy_nxt;
  logic [OUT_W-1:0]  resv;
  logic              go;

  assign go = (state == ST_WAIT) && (gap_cnt == '0) && !busy[ptr] &&
              (up_count >= CNT_W'(PIPE_WORDS)) && (dn_free > CNT_W'(resv));

  assign disp_vld = go;
  assign disp_idx = ptr;
  assign up_rd_en = (state == ST_FEED);

  always_comb begin
    busy_nxt = busy;
    if (go)      busy_nxt[ptr]     = 1'b1;
    if (rel_vld) busy_nxt[rel_idx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (state == ST_FEED) core_data <= up_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_WAIT;
      ptr        <= '0;
      sel        <= '0;
      feed_cnt   <= '0;
      gap_cnt    <= '0;
      busy       <= '0;
      resv       <= '0;
      core_start <= '0;
      core_load  <= '0;
    end else begin
      core_start <= '0;
      core_load  <= '0;
      busy       <= busy_nxt;

      if (go)                 gap_cnt <= GAP_W'(SPACING - 1);
      else if (gap_cnt != '0) gap_cnt <= gap_cnt - 1'b1;

      case ({go, rel_vld})
        2'b10:   resv <= resv + 1'b1;
        2'b01:   resv <= resv - 1'b1;
        default: resv <= resv;
      endcase

      case (state)
        ST_WAIT: begin
          if (go) begin
            state    <= ST_FEED;
            sel      <= ptr;
            feed_cnt <= '0;
            ptr      <= (ptr == IDX_W'(N_CORES - 1)) ? '0 : ptr + 1'b1;
          end
        end
        ST_FEED: begin
          core_load <= ONE << sel;
          if (feed_cnt == '0) core_start <= ONE << sel;
          feed_cnt <= feed_cnt + 1'b1;
          if (feed_cnt == FEED_W'(PIPE_WORDS - 1)) state <= ST_WAIT;
        end
        default: state <= ST_WAIT;
      endcase
    end
  end

  // ---- checker state: spacing and rotation of starts ----
  logic [GAP_W-1:0]  since_q;
  logic              seen_q;
  logic [IDX_W-1:0]  last_q, start_idx, last_nxt;

  always_comb begin
    start_idx = '0;
    for (int i = 0; i < N_CORES; i++)
      if (core_start[i]) start_idx = IDX_W'(i);
  end
  assign last_nxt = (last_q == IDX_W'(N_CORES - 1)) ? '0 : last_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= '0;
      seen_q  <= 1'b0;
      last_q  <= '0;
    end else if (|core_start) begin
      since_q <= GAP_W'(1);
      seen_q  <= 1'b1;
      last_q  <= start_idx;
    end else if (since_q != GAP_W'(SPACING)) begin
      since_q <= since_q + 1'b1;
    end
  end

  // R2
  feed_enough_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(up_rd_en) |-> ($past(up_count) >= CNT_W'(PIPE_WORDS)));
  // R6
  start_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    ((|core_start) && seen_q) |-> (since_q >= GAP_W'(SPACING)));
  // R4
  rr_order_chk: assert property (@(posedge clk) disable iff (rst)
    ((|core_start) && seen_q) |-> (core_start == (ONE << last_nxt)));
  // R1
  first_start_chk: assert property (@(posedge clk) disable iff (rst)
    ((|core_start) && !seen_q) |-> core_start[0]);
  // R5
  load_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(core_load) && ((core_start & ~core_load) == '0));

endmodule

// File: rtl/rr_core_sched.sv
module rr_core_sched import sched_pkg::*; #(
  parameter int N_CORES     = 3,
  parameter int IN_W        = 32,
  parameter int RES_W       = 32,
  parameter int CNT_W       = 8,
  parameter int PIPE_WORDS  = 4,
  parameter int EXEC_CYCLES = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CNT_W-1:0]         up_count,
  output logic                     up_rd_en,
  input  logic [IN_W-1:0]          up_data,
  input  logic [CNT_W-1:0]         dn_free,
  output logic                     dn_wr_en,
  output logic [RES_W-1:0]         dn_data,
  output logic [N_CORES-1:0]       core_start,
  output logic [N_CORES-1:0]       core_load,
  output logic [IN_W-1:0]          core_data,
  input  logic [N_CORES-1:0]       core_done,
  input  logic [N_CORES*RES_W-1:0] core_result
);
  localparam int IDX_W   = max_int(1, $clog2(N_CORES));
  localparam int SPACING = max_int(ceil_div(EXEC_CYCLES, N_CORES), PIPE_WORDS + 1);
  localparam logic [N_CORES-1:0] ONE = N_CORES'(1);

  logic               disp_vld;
  logic [IDX_W-1:0]   disp_idx;
  logic [IDX_W-1:0]   head_idx, wr_idx;
  logic               oq_empty, oq_full;
  logic [N_CORES-1:0] buf_v, clr;
  logic [N_CORES*RES_W-1:0] buf_data;
  logic               wb_go;

  sched_dispatch #(
    .N_CORES(N_CORES), .IDX_W(IDX_W), .IN_W(IN_W), .CNT_W(CNT_W),
    .PIPE_WORDS(PIPE_WORDS), .SPACING(SPACING)
  ) u_dispatch (
    .clk(clk), .rst(rst),
    .up_count(up_count), .up_data(up_data), .up_rd_en(up_rd_en),
    .dn_free(dn_free),
    .rel_vld(dn_wr_en), .rel_idx(wr_idx),
    .core_start(core_start), .core_load(core_load), .core_data(core_data),
    .disp_vld(disp_vld), .disp_idx(disp_idx)
  );

  sched_order_q #(.DEPTH(N_CORES), .W(IDX_W)) u_order (
    .clk(clk), .rst(rst),
    .push(disp_vld), .push_data(disp_idx),
    .pop(wb_go), .head(head_idx),
    .empty(oq_empty), .full(oq_full)
  );

  sched_result_buf #(.N_CORES(N_CORES), .RES_W(RES_W)) u_resbuf (
    .clk(clk), .rst(rst),
    .core_done(core_done), .core_result(core_result),
    .clr(clr), .buf_v(buf_v), .buf_data(buf_data)
  );

  assign wb_go = !oq_empty && buf_v[head_idx];
  assign clr   = wb_go ? (ONE << head_idx) : '0;

  always_ff @(posedge clk) begin
    if (wb_go) dn_data <= buf_data[head_idx*RES_W +: RES_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_wr_en <= 1'b0;
      wr_idx   <= '0;
    end else begin
      dn_wr_en <= wb_go;
      if (wb_go) wr_idx <= head_idx;
    end
  end

  // R10
  dn_room_chk: assert property (@(posedge clk) disable iff (rst)
    dn_wr_en |-> (dn_free != '0));
  // R9
  start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (|core_start) |-> ((core_start & buf_v) == '0));
  // R7
  order_cap_chk: assert property (@(posedge clk) disable iff (rst)
    disp_vld |-> !oq_full);

endmodule

// File: tb/test_rr_core_sched.sv
module test_rr_core_sched;
  localparam int N     = 3;
  localparam int IN_W  = 32;
  localparam int RES_W = 32;
  localparam int CNT_W = 8;
  localparam int PW    = 4;
  localparam int EXEC  = 24;
  localparam int GAPC  = 8;   // max(ceil(24/3), 4+1)

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CNT_W-1:0] up_count = '0;
  logic             up_rd_en;
  logic [IN_W-1:0]  up_data = '0;
  logic [CNT_W-1:0] dn_free = '0;
  logic             dn_wr_en;
  logic [RES_W-1:0] dn_data;
  logic [N-1:0]     core_start, core_load;
  logic [IN_W-1:0]  core_data;
  logic [N-1:0]     core_done = '0;
  logic [N*RES_W-1:0] core_result = '0;

  rr_core_sched #(.N_CORES(N), .IN_W(IN_W), .RES_W(RES_W), .CNT_W(CNT_W),
                  .PIPE_WORDS(PW), .EXEC_CYCLES(EXEC)) i_rr_core_sched (
    .clk(clk), .rst(rst), .up_count(up_count), .up_rd_en(up_rd_en),
    .up_data(up_data), .dn_free(dn_free), .dn_wr_en(dn_wr_en), .dn_data(dn_data),
    .core_start(core_start), .core_load(core_load), .core_data(core_data),
    .core_done(core_done), .core_result(core_result));

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  bit finished = 0;

  logic [31:0] pend_q[$], up_q[$], dn_q[$], exp_q[$];
  int disp_core_q[$], wr_cyc_q[$];
  int dn_cap = 8;
  bit drain = 1;
  logic [31:0] cur_h = '0;
  int cur_n = 0, cyc = 0, starts = 0, rr_next = 0, last_start = -1000;
  int extra[N], tmr[N], ldcnt[N], done_cyc[N];
  logic [31:0] acc[N];
  bit owed[N];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mix(input logic [31:0] h, input logic [31:0] w);
    return ((h << 5) + h) ^ w;
  endfunction

  task automatic push_word(input logic [31:0] w);
    pend_q.push_back(w);
    cur_h = (cur_n == 0) ? w : mix(cur_h, w);
    cur_n++;
    if (cur_n == PW) begin
      exp_q.push_back(cur_h);
      cur_n = 0;
    end
  endtask

  task automatic push_items(input int n, input int seed);
    for (int k = 0; k < n * PW; k++) push_word(32'(seed * 97 + k * 13 + 7));
  endtask

  task automatic wait_empty();
    int k = 0;
    while ((exp_q.size() != 0) && (k < 4000)) begin
      @(negedge clk);
      k++;
    end
    repeat (6) @(negedge clk);
  endtask

  // FIFO models, core models and per-clock reference checks
  always @(posedge clk) begin
    logic [N-1:0] nd;
    nd = '0;
    cyc++;
    if (!rst) begin
      if (up_rd_en) begin
        chk(up_q.size() > 0, "R2 read from empty upstream", up_q.size(), 1);
        if (up_q.size() > 0) void'(up_q.pop_front());
      end
      if (dn_wr_en) begin
        chk(dn_q.size() < dn_cap, "R10 write into full downstream", dn_q.size(), dn_cap - 1);
        dn_q.push_back(dn_data);
        wr_cyc_q.push_back(cyc);
        if (exp_q.size() > 0) begin
          chk(dn_data == exp_q[0], "R7 result order/value", dn_data, exp_q[0]);
          void'(exp_q.pop_front());
        end else chk(0, "R7 unexpected result", dn_data, 0);
        if (disp_core_q.size() > 0) owed[disp_core_q.pop_front()] = 0;
      end
      if (drain && dn_q.size() > 0) void'(dn_q.pop_front());
      for (int i = 0; i < N; i++) begin
        if (core_start[i]) begin
          chk(i == rr_next, "R4 rotation", i, rr_next);
          chk(!owed[i], "R9 restart before write-back", owed[i], 0);
          if (last_start >= 0)
            chk(cyc - last_start >= GAPC, "R6 start spacing", cyc - last_start, GAPC);
          chk(core_load[i], "R5 start without word", core_load[i], 1);
          owed[i] = 1;
          disp_core_q.push_back(i);
          rr_next = (i + 1) % N;
          last_start = cyc;
          starts++;
          ldcnt[i] = 0;
          tmr[i] = EXEC + extra[i];
        end else if (tmr[i] > 0) begin
          tmr[i]--;
          if (tmr[i] == 0) begin
            chk(ldcnt[i] == PW, "R5 words per item", ldcnt[i], PW);
            nd[i] = 1'b1;
            done_cyc[i] = cyc;
            core_result[i*RES_W +: RES_W] <= acc[i];
          end
        end
        if (core_load[i]) begin
          acc[i] = core_start[i] ? core_data : mix(acc[i], core_data);
          ldcnt[i]++;
        end
      end
      while (pend_q.size() > 0) up_q.push_back(pend_q.pop_front());
    end
    core_done <= nd;
    up_count  <= CNT_W'(up_q.size());
    up_data   <= (up_q.size() > 0) ? up_q[0] : '0;
    dn_free   <= CNT_W'(dn_cap - dn_q.size());
  end

  initial begin
    int s0, ci, base;
    for (int i = 0; i < N; i++) begin
      extra[i] = 0; tmr[i] = 0; ldcnt[i] = 0; owed[i] = 0; acc[i] = '0; done_cyc[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(up_rd_en == 0, "R1 up_rd_en after reset", up_rd_en, 0);
    chk(dn_wr_en == 0, "R1 dn_wr_en after reset", dn_wr_en, 0);
    chk(core_start == 0 && core_load == 0, "R1 core strobes after reset", core_start, 0);

    // R2 partial item stalls
    for (int k = 0; k < PW - 1; k++) push_word(32'(100 + k));
    repeat (30) @(negedge clk);
    chk(starts == 0, "R2 no dispatch on partial item", starts, 0);
    push_word(32'h55);
    repeat (12) @(negedge clk);
    chk(starts == 1, "R2 dispatch once item complete", starts, 1);
    wait_empty();

    // R4/R6/R7 streaming
    s0 = starts;
    push_items(9, 3);
    wait_empty();
    chk(starts - s0 == 9, "R7 all streamed items done", starts - s0, 9);
    chk(exp_q.size() == 0, "R7 no missing results", exp_q.size(), 0);

    // R3 reservation against downstream space
    drain = 0; dn_cap = 2;
    repeat (4) @(negedge clk);
    s0 = starts;
    push_items(4, 11);
    repeat (200) @(negedge clk);
    chk(starts - s0 == 2, "R3 starts capped by free space", starts - s0, 2);
    chk(dn_q.size() == 2, "R3 downstream filled", dn_q.size(), 2);
    drain = 1;
    wait_empty();
    chk(starts - s0 == 4, "R3 resumes after drain", starts - s0, 4);
    dn_cap = 8;
    repeat (4) @(negedge clk);

    // R7 out-of-order finish
    ci = rr_next;
    extra[ci] = 12;
    push_items(3, 21);
    wait_empty();
    chk(done_cyc[(ci + 1) % N] < done_cyc[ci], "R7 later core finished first",
        done_cyc[(ci + 1) % N], done_cyc[ci]);
    extra[ci] = 0;

    // R8 simultaneous finish
    ci = rr_next;
    extra[ci] = GAPC;
    base = wr_cyc_q.size();
    push_items(2, 31);
    wait_empty();
    chk(done_cyc[ci] == done_cyc[(ci + 1) % N], "R8 same-cycle finish exercised",
        done_cyc[ci], done_cyc[(ci + 1) % N]);
    chk(wr_cyc_q.size() == base + 2, "R8 both results written", wr_cyc_q.size(), base + 2);
    if (wr_cyc_q.size() >= base + 2)
      chk(wr_cyc_q[base + 1] - wr_cyc_q[base] == 1, "R8 back-to-back writes",
          wr_cyc_q[base + 1] - wr_cyc_q[base], 1);
    extra[ci] = 0;

    // R9/R4 slow core in turn stalls dispatch
    ci = rr_next;
    extra[ci] = 100;
    s0 = starts;
    push_items(4, 41);
    repeat (80) @(negedge clk);
    chk(starts - s0 == 3, "R9 fourth item waits on busy core", starts - s0, 3);
    wait_empty();
    chk(starts - s0 == 4, "R9 fourth item dispatched later", starts - s0, 4);
    chk(rr_next == (ci + 1) % N, "R4 fourth item went to slow core", rr_next, (ci + 1) % N);
    extra[ci] = 0;

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule